// File: doc/BRIEF.md
# Two-Lane Whole-Transaction Dispatcher

This block sits between a single incoming command stream and two downstream input FIFOs, each of which feeds its own decoder. Commands arrive as word beats of varying count. The first beat of each command carries a start flag. The dispatcher sends every beat of one command to the same FIFO, and it gives each new command to the lane that the previous command did not use. Two long commands that arrive back to back are therefore decoded at the same time.

The lane choice depends only on where the start flags fall. It never depends on the command contents. Commands keep their arrival order because the lanes strictly take turns. If a new command must go to a lane whose FIFO is full, the dispatcher holds the stream by dropping its ready output. It does not hand the command to the free lane. The data path is combinational: a beat is written in the same cycle it is accepted. Only the lane state is registered.

Top module: `txn_lane_dispatch`

## Requirements
- R1: After reset no write enable is active while `in_valid` is low, and the first beat with `in_sot` high is written to lane 0.
- R2: A beat with `in_sot` low is written to the same lane as the most recent accepted start beat, so a command is never split across lanes.
- R3: Each accepted start beat after the first goes to the lane opposite the previous command's lane, whatever the data word holds.
- R4: When a start beat targets a lane whose full flag is high, `in_ready` is low and neither lane is written. Once that flag drops, the waiting beat is written to that same lane.
- R5: A write enable is active only in a cycle with both `in_valid` and `in_ready` high, every such cycle writes exactly one lane, and the two enables are never active together.
- R6: A continuation beat (`in_sot` low) is stalled (`in_ready` low) only by its own lane's full flag. The other lane's full flag has no effect on it.
- R7: The data output of the written lane equals `in_data` in the cycle of the write.
- R8: Beats accepted before the first start beat after reset are written to lane 0.
- R9: A cycle with `in_valid` low writes nothing and does not change the lane state, even when `in_sot` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_data | input | DATA_W | Stream data word |
| in_sot | input | 1 | High on the first beat of a command |
| in_valid | input | 1 | Stream beat valid |
| in_ready | output | 1 | Dispatcher can accept the beat |
| lane0_full | input | 1 | Lane 0 FIFO full flag |
| lane1_full | input | 1 | Lane 1 FIFO full flag |
| lane0_wr | output | 1 | Lane 0 FIFO write enable |
| lane0_data | output | DATA_W | Lane 0 FIFO write data |
| lane1_wr | output | 1 | Lane 1 FIFO write enable |
| lane1_data | output | DATA_W | Lane 1 FIFO write data |

## Verification
The assertions check on every cycle that at most one enable fires and only on a handshake, that no full lane is written, that the written data matches the input, and that lane choice follows the start flags. The checker rebuilds the lane sequence from the write enables alone.

Only the bench scenarios show the following:
- the exact stall and resume sequence when the target lane is full;
- the other lane's full flag being ignored during a continuation;
- a start flag with `in_valid` low leaving the lane state unchanged;
- the handling of orphan beats before the first start.

// File: rtl/dispatch_pkg.sv
// Package: shared lane type for the transaction dispatcher.
// Assumes exactly two lanes; the lane number is one bit.
package dispatch_pkg;

    typedef enum logic {
        LANE_A = 1'b0,
        LANE_B = 1'b1
    } lane_e;

    // Returns the lane that is not the given one.
    function automatic lane_e flip_lane(input lane_e l);
        return (l == LANE_A) ? LANE_B : LANE_A;
    endfunction

endpackage

// File: rtl/lane_select.sv
// Module: lane_select
// Holds the current lane and picks the target lane of each incoming beat.
// A start beat goes to the opposite lane, except the first one after reset,
// which goes to lane A. Any other beat stays on the current lane. The stream
// is ready when the target lane is not full.
// Assumes: synchronous active-low reset; full flags are valid every cycle.
module lane_select
    import dispatch_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       beat_valid,
    input  logic       beat_sot,
    input  logic [1:0] full_vec,
    output lane_e      tgt_lane,
    output logic       beat_ready,
    output logic       beat_accept
);

    lane_e cur_q;
    logic  fresh_q;

    // Target lane for the present beat.
    always_comb begin
        if (beat_sot) begin
            tgt_lane = fresh_q ? LANE_A : flip_lane(cur_q);
        end else begin
            tgt_lane = cur_q;
        end
    end

    // Ready and accept for the present beat.
    always_comb begin
        beat_ready  = ~full_vec[tgt_lane];
        beat_accept = beat_valid & beat_ready;
    end

    // Commit the lane when a start beat is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q   <= LANE_A;
            fresh_q <= 1'b1;
        end else if (beat_accept && beat_sot) begin
            cur_q   <= tgt_lane;
            fresh_q <= 1'b0;
        end
    end

endmodule

// File: rtl/lane_port.sv
// Module: lane_port
// Write side of one lane. It raises the write enable when an accepted beat
// targets this lane and passes the stream word to the FIFO.
// Assumes: accept is already qualified with valid and ready.
module lane_port
    import dispatch_pkg::*;
#(
    parameter int    DATA_W  = 64,
    parameter lane_e LANE_ID = LANE_A
) (
    input  lane_e              tgt_lane,
    input  logic               beat_accept,
    input  logic [DATA_W-1:0]  beat_data,
    output logic               fifo_wr,
    output logic [DATA_W-1:0]  fifo_data
);

    // Write enable and data for this lane.
    always_comb begin
        fifo_wr   = beat_accept && (tgt_lane == LANE_ID);
        fifo_data = beat_data;
    end

endmodule

// File: rtl/txn_lane_dispatch.sv
// Module: txn_lane_dispatch (top)
// Steers whole variable-length commands from one stream into two FIFOs.
// The lanes take strict turns at each start beat. The stream stalls when the
// chosen lane is full. Zero-latency data path; only the lane state is
// registered.
// Assumes: synchronous active-low reset; FIFO full flags are combinational
// inputs that are valid in the same cycle.
module txn_lane_dispatch
    import dispatch_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_sot,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              lane0_full,
    input  logic              lane1_full,
    output logic              lane0_wr,
    output logic [DATA_W-1:0] lane0_data,
    output logic              lane1_wr,
    output logic [DATA_W-1:0] lane1_data
);

    localparam int LANES = 2;

    lane_e             tgt_lane;
    logic              accept;
    logic [LANES-1:0]  full_vec;
    logic [LANES-1:0]  wr_vec;
    logic [DATA_W-1:0] data_arr [LANES];

    // Gather the full flags into one vector.
    always_comb full_vec = {lane1_full, lane0_full};

    lane_select u_sel (
        .clk         (clk),
        .rst_n       (rst_n),
        .beat_valid  (in_valid),
        .beat_sot    (in_sot),
        .full_vec    (full_vec),
        .tgt_lane    (tgt_lane),
        .beat_ready  (in_ready),
        .beat_accept (accept)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        lane_port #(
            .DATA_W  (DATA_W),
            .LANE_ID ((i == 0) ? LANE_A : LANE_B)
        ) u_port (
            .tgt_lane    (tgt_lane),
            .beat_accept (accept),
            .beat_data   (in_data),
            .fifo_wr     (wr_vec[i]),
            .fifo_data   (data_arr[i])
        );
    end

    // Drive the per-lane output ports.
    always_comb begin
        lane0_wr   = wr_vec[0];
        lane1_wr   = wr_vec[1];
        lane0_data = data_arr[0];
        lane1_data = data_arr[1];
    end

endmodule

// File: rtl/txn_lane_dispatch_chk.sv
// Module: txn_lane_dispatch_chk
// Port-level checker. It rebuilds the lane history from the write enables
// and checks handshake, exclusivity, full safety, data and alternation.
module txn_lane_dispatch_chk #(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] in_data,
    input logic              in_sot,
    input logic              in_valid,
    input logic              in_ready,
    input logic              lane0_full,
    input logic              lane1_full,
    input logic              lane0_wr,
    input logic [DATA_W-1:0] lane0_data,
    input logic              lane1_wr,
    input logic [DATA_W-1:0] lane1_data
);

    logic sot_seen_q;
    logic last_q;

    // Track whether a start beat was taken and which lane was written last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sot_seen_q <= 1'b0;
            last_q     <= 1'b0;
        end else begin
            if (lane0_wr || lane1_wr) last_q <= lane1_wr;
            if ((lane0_wr || lane1_wr) && in_sot) sot_seen_q <= 1'b1;
        end
    end

    p_one_hot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({lane1_wr, lane0_wr}));

    p_wr_handshake_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lane0_wr || lane1_wr) |-> (in_valid && in_ready));

    p_take_writes_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |-> (lane0_wr || lane1_wr));

    p_start_lane0_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!sot_seen_q && in_valid && in_ready) |-> lane0_wr);

    p_no_split_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sot_seen_q && in_valid && in_ready && !in_sot) |->
            (last_q ? lane1_wr : lane0_wr));

    p_alternate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sot_seen_q && in_valid && in_ready && in_sot) |->
            (last_q ? lane0_wr : lane1_wr));

    p_no_overflow0_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lane0_wr |-> !lane0_full);

    p_no_overflow1_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lane1_wr |-> !lane1_full);

    p_data0_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lane0_wr |-> (lane0_data == in_data));

    p_data1_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lane1_wr |-> (lane1_data == in_data));

    p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> (!lane0_wr && !lane1_wr));

endmodule

bind txn_lane_dispatch txn_lane_dispatch_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_data    (in_data),
    .in_sot     (in_sot),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .lane0_full (lane0_full),
    .lane1_full (lane1_full),
    .lane0_wr   (lane0_wr),
    .lane0_data (lane0_data),
    .lane1_wr   (lane1_wr),
    .lane1_data (lane1_data)
);

// File: tb/txn_lane_dispatch_tb.sv
module txn_lane_dispatch_tb;

    localparam int DW = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          in_sot = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic          lane0_full = 1'b0;
    logic          lane1_full = 1'b0;
    logic          lane0_wr, lane1_wr;
    logic [DW-1:0] lane0_data, lane1_data;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    txn_lane_dispatch #(.DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_sot(in_sot),
        .in_valid(in_valid), .in_ready(in_ready),
        .lane0_full(lane0_full), .lane1_full(lane1_full),
        .lane0_wr(lane0_wr), .lane0_data(lane0_data),
        .lane1_wr(lane1_wr), .lane1_data(lane1_data)
    );

    // exp_lane: 0 or 1 = that lane is written, 2 = no write expected.
    task automatic beat(input logic v, input logic sot, input logic [DW-1:0] d,
                        input logic f0, input logic f1, input int exp_lane,
                        input logic exp_rdy, input string req);
        @(negedge clk);
        in_valid = v; in_sot = sot; in_data = d;
        lane0_full = f0; lane1_full = f1;
        #1;
        total++;
        if (in_ready !== exp_rdy ||
            lane0_wr !== (exp_lane == 0) || lane1_wr !== (exp_lane == 1) ||
            (exp_lane == 0 && lane0_data !== d) ||
            (exp_lane == 1 && lane1_data !== d)) begin
            bad++;
            $display("FAIL %s: rdy=%0b wr0=%0b wr1=%0b d0=%h d1=%h exp rdy=%0b lane=%0d d=%h",
                     req, in_ready, lane0_wr, lane1_wr, lane0_data, lane1_data,
                     exp_rdy, exp_lane, d);
        end
        @(posedge clk);
    endtask

    task automatic t_reset();
        beat(0, 0, 64'h0, 0, 0, 2, 1, "R1 idle after reset");
        beat(0, 1, 64'h1, 0, 0, 2, 1, "R9 sot without valid");
    endtask

    task automatic t_orphan();
        beat(1, 0, 64'hA0, 0, 0, 0, 1, "R8 orphan beat lane0");
        beat(1, 0, 64'hA1, 0, 0, 0, 1, "R8 orphan beat lane0 again");
    endtask

    task automatic t_alternate();
        beat(1, 1, 64'hB0, 0, 0, 0, 1, "R1 first sot lane0");
        beat(1, 0, 64'hB1, 0, 0, 0, 1, "R2 continuation lane0");
        beat(1, 1, 64'hC0, 0, 0, 1, 1, "R3 second sot lane1");
        beat(1, 0, 64'hC1, 0, 0, 1, 1, "R2 continuation lane1");
        beat(1, 0, 64'hC2, 0, 0, 1, 1, "R2 long continuation lane1");
        beat(1, 1, 64'hD0, 0, 0, 0, 1, "R3 single-beat lane0");
        beat(1, 1, 64'hD0, 0, 0, 1, 1, "R3 same word still alternates lane1");
        beat(1, 1, 64'hE0, 0, 0, 0, 1, "R3 back-to-back lane0");
    endtask

    task automatic t_full_stall();
        beat(1, 1, 64'hF0, 0, 1, 2, 0, "R4 stall on full lane1");
        beat(1, 1, 64'hF0, 0, 1, 2, 0, "R4 still stalled");
        beat(1, 1, 64'hF0, 0, 0, 1, 1, "R4 resume to lane1");
        beat(1, 0, 64'hF1, 1, 0, 1, 1, "R6 other lane full ignored");
        beat(1, 0, 64'hF2, 0, 1, 2, 0, "R6 own lane full stalls");
        beat(1, 0, 64'hF2, 0, 0, 1, 1, "R6 continuation resumes lane1");
    endtask

    task automatic t_idle_hold();
        beat(0, 1, 64'h11, 0, 0, 2, 1, "R9 idle sot no write");
        beat(1, 0, 64'h12, 0, 0, 1, 1, "R9 lane unchanged after idle sot");
        beat(1, 1, 64'h13, 0, 0, 0, 1, "R5 handshake writes lane0");
    endtask

    task automatic t_rereset();
        @(negedge clk); rst_n = 0; in_valid = 0;
        @(negedge clk); rst_n = 1;
        beat(1, 1, 64'h21, 0, 0, 0, 1, "R1 first sot lane0 after reset");
        beat(1, 1, 64'h22, 0, 0, 1, 1, "R3 next sot lane1 after reset");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        t_reset();
        t_orphan();
        t_alternate();
        t_full_stall();
        t_idle_hold();
        t_rereset();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: run did not finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule